// File: doc/BRIEF.md
# Link Credit Flow Control Unit

This block keeps a link's receive buffers from overflowing by exchanging credit information with the far end. It has a receive-side advertiser and a transmit-side gate. The advertiser runs a programmable timer. Each time the timer runs out, it raises a request for a flow-control packet. The packet carries the local lane's credit limit, which is the sum of the blocks received so far and the free blocks in the local buffer. It also carries the running count of blocks this end has sent. The request is made on every timer expiry, even when nothing has changed, so a lost update is repaired by the next one.

The transmit gate tracks the credit limit that the far end advertises for the data lane. It decides whether each pending packet may go. All block counts are 12-bit values that wrap modulo 4096. One block is 64 bytes. The management lane is never gated: its packets are always granted, and the far end drops them if its buffer is full.

Top module: `credit_flow_ctl`

## Requirements
- R1: While reset is asserted, and in the cycle after it, `fc_req` and `tx_grant` are 0.
- R2: Until the first credit update for the data lane arrives after reset, every data-lane request is refused (`tx_grant` stays 0).
- R3: A request in cycle t produces a `tx_grant` pulse in cycle t+1 exactly when the packet may go. A data-lane packet (`tx_lane`=0) of N blocks may go only if (limit − sent − N) mod 4096 ≤ 2048. Here limit is the last accepted credit limit and sent is the block count before the request.
- R4: Each granted data-lane packet adds N to the 12-bit sent count, modulo 4096. Refused packets and management packets leave the count unchanged.
- R5: A management-lane request (`tx_lane`=1) is always granted in the next cycle, whatever the credit state.
- R6: A credit update is accepted only when `cu_lane` is 0 (the data lane). An update with any other lane code has no effect on later grant decisions.
- R7: `fc_req` rises on the P-th clock edge after reset is released, or after a handshake (`fc_req` and `fc_ack` both 1 at an edge) takes the request down. It stays high until that handshake completes. The timer restarts only on the handshake.
- R8: P equals `fc_period` when that input is non-zero. When `fc_period` is 0, P is 65536.
- R9: When `fc_req` rises, `fc_credit_limit` holds (`buf_rcvd` + `buf_free`) mod 4096 and `fc_blocks_sent` holds the sent count, both as they were at that edge. Both fields stay unchanged while the request waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fc_period | input | 17 | Advertisement interval in cycles; 0 selects 65536 |
| buf_rcvd | input | 12 | Blocks received so far into the local data-lane buffer (mod 4096) |
| buf_free | input | 12 | Free blocks in the local data-lane buffer |
| fc_ack | input | 1 | Flow-control packet has been taken for sending |
| fc_req | output | 1 | Flow-control packet request |
| fc_credit_limit | output | 12 | Advertised credit limit field |
| fc_blocks_sent | output | 12 | Advertised total-blocks-sent field |
| cu_valid | input | 1 | Credit update from the link packet checker |
| cu_lane | input | 4 | Lane code of the update (0 = data lane) |
| cu_limit | input | 12 | Far-end credit limit |
| tx_req | input | 1 | Packet ready to send |
| tx_lane | input | 1 | 0 = data lane, 1 = management lane |
| tx_blocks | input | 12 | Packet length in blocks |
| tx_grant | output | 1 | One-cycle permission for the request of the previous cycle |

## Verification
The bench first targets the credit window edges. A difference of exactly 2048 must be allowed and one more than that refused. A design that compared against 2047, or that did not wrap, would flip those grants. It would also mis-handle the packet whose sum crosses 4096, because the sent count would leave 12 bits. The bench also covers the state before any credit arrives, where a gate that read a zero limit as a large window would let a 2048-block packet through. It sends foreign-lane updates, which a careless decoder would take as a new limit. On the advertiser side, it measures the exact spacing of requests, including the 65536-cycle default. It holds requests unacknowledged to catch a timer that restarts on expiry instead of on the handshake, or fields that drift while the request waits.

// File: rtl/flowctl_pkg.sv
package flowctl_pkg;
  typedef enum logic [0:0] {
    LANE_DATA = 1'b0,
    LANE_MGMT = 1'b1
  } lane_e;
endpackage

// File: rtl/fc_tx_gate.sv
module fc_tx_gate
  import flowctl_pkg::*;
#(
  parameter int BLK_W  = 12,
  parameter int LANE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cu_valid,
  input  logic [LANE_W-1:0] cu_lane,
  input  logic [BLK_W-1:0]  cu_limit,
  input  logic              tx_req,
  input  logic              tx_lane,
  input  logic [BLK_W-1:0]  tx_blocks,
  output logic              tx_grant,
  output logic [BLK_W-1:0]  blocks_sent
);
  localparam logic [BLK_W-1:0] HALF = BLK_W'(1) << (BLK_W - 1);

  logic [BLK_W-1:0] limit_q;
  logic             have_q;
  logic [BLK_W-1:0] margin;
  logic             credit_ok;
  logic             mgmt;
  logic             grant_d;

  assign mgmt      = (lane_e'(tx_lane) == LANE_MGMT);
  // wrap-aware headroom after the pending packet
  assign margin    = limit_q - blocks_sent - tx_blocks;
  assign credit_ok = have_q && (margin <= HALF);
  assign grant_d   = tx_req && (mgmt || credit_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_q     <= '0;
      have_q      <= 1'b0;
      blocks_sent <= '0;
      tx_grant    <= 1'b0;
    end else begin
      tx_grant <= grant_d;
      if (grant_d && !mgmt)
        blocks_sent <= blocks_sent + tx_blocks;
      if (cu_valid && (cu_lane == '0)) begin
        limit_q <= cu_limit;
        have_q  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fc_adv_timer.sv
module fc_adv_timer #(
  parameter int PER_W      = 17,
  parameter int DEF_PERIOD = 65536,
  parameter int BLK_W      = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PER_W-1:0] period_cfg,
  input  logic             ack,
  input  logic [BLK_W-1:0] buf_rcvd,
  input  logic [BLK_W-1:0] buf_free,
  input  logic [BLK_W-1:0] sent_now,
  output logic             req,
  output logic [BLK_W-1:0] adv_limit,
  output logic [BLK_W-1:0] adv_sent
);
  localparam logic [PER_W-1:0] DEF_P = PER_W'(DEF_PERIOD);

  logic [PER_W-1:0] tick_q;
  logic [PER_W-1:0] last_tick;

  assign last_tick = ((period_cfg == '0) ? DEF_P : period_cfg) - PER_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q    <= '0;
      req       <= 1'b0;
      adv_limit <= '0;
      adv_sent  <= '0;
    end else if (req) begin
      if (ack) begin
        req    <= 1'b0;
        tick_q <= '0;
      end
    end else if (tick_q >= last_tick) begin
      req       <= 1'b1;
      tick_q    <= '0;
      adv_limit <= buf_rcvd + buf_free;
      adv_sent  <= sent_now;
    end else begin
      tick_q <= tick_q + PER_W'(1);
    end
  end
endmodule

// File: rtl/credit_flow_ctl.sv
module credit_flow_ctl #(
  parameter int BLK_W      = 12,
  parameter int LANE_W     = 4,
  parameter int PER_W      = 17,
  parameter int DEF_PERIOD = 65536
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PER_W-1:0]  fc_period,
  input  logic [BLK_W-1:0]  buf_rcvd,
  input  logic [BLK_W-1:0]  buf_free,
  input  logic              fc_ack,
  output logic              fc_req,
  output logic [BLK_W-1:0]  fc_credit_limit,
  output logic [BLK_W-1:0]  fc_blocks_sent,
  input  logic              cu_valid,
  input  logic [LANE_W-1:0] cu_lane,
  input  logic [BLK_W-1:0]  cu_limit,
  input  logic              tx_req,
  input  logic              tx_lane,
  input  logic [BLK_W-1:0]  tx_blocks,
  output logic              tx_grant
);
  logic [BLK_W-1:0] sent_cnt;

  fc_tx_gate #(.BLK_W(BLK_W), .LANE_W(LANE_W)) u_gate (
    .clk        (clk),
    .rst        (rst),
    .cu_valid   (cu_valid),
    .cu_lane    (cu_lane),
    .cu_limit   (cu_limit),
    .tx_req     (tx_req),
    .tx_lane    (tx_lane),
    .tx_blocks  (tx_blocks),
    .tx_grant   (tx_grant),
    .blocks_sent(sent_cnt)
  );

  fc_adv_timer #(.PER_W(PER_W), .DEF_PERIOD(DEF_PERIOD), .BLK_W(BLK_W)) u_adv (
    .clk       (clk),
    .rst       (rst),
    .period_cfg(fc_period),
    .ack       (fc_ack),
    .buf_rcvd  (buf_rcvd),
    .buf_free  (buf_free),
    .sent_now  (sent_cnt),
    .req       (fc_req),
    .adv_limit (fc_credit_limit),
    .adv_sent  (fc_blocks_sent)
  );
endmodule

// File: rtl/credit_flow_ctl_chk.sv
module credit_flow_ctl_chk #(
  parameter int BLK_W  = 12,
  parameter int LANE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              fc_req,
  input logic              fc_ack,
  input logic [BLK_W-1:0]  fc_credit_limit,
  input logic [BLK_W-1:0]  fc_blocks_sent,
  input logic              cu_valid,
  input logic [LANE_W-1:0] cu_lane,
  input logic              tx_req,
  input logic              tx_lane,
  input logic              tx_grant
);
  logic seen_cu;

  always_ff @(posedge clk) begin
    if (rst) seen_cu <= 1'b0;
    else if (cu_valid && (cu_lane == '0)) seen_cu <= 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!fc_req && !tx_grant));

  // R2
  no_credit_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!seen_cu && tx_req && !tx_lane) |=> !tx_grant);

  // R3
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_req |=> !tx_grant);

  // R5
  mgmt_always_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_req && tx_lane) |=> tx_grant);

  // R7
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (fc_req && fc_ack) |=> !fc_req);

  // R9
  fields_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fc_req && !fc_ack) |=> (fc_req && $stable(fc_credit_limit) && $stable(fc_blocks_sent)));
endmodule

bind credit_flow_ctl credit_flow_ctl_chk #(.BLK_W(BLK_W), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst(rst), .fc_req(fc_req), .fc_ack(fc_ack),
  .fc_credit_limit(fc_credit_limit), .fc_blocks_sent(fc_blocks_sent),
  .cu_valid(cu_valid), .cu_lane(cu_lane), .tx_req(tx_req),
  .tx_lane(tx_lane), .tx_grant(tx_grant)
);

// File: tb/credit_flow_ctl_tb.sv
`timescale 1ns/1ps
module credit_flow_ctl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [16:0] fc_period = '0;
  logic [11:0] buf_rcvd = '0, buf_free = '0;
  logic        fc_ack = 1'b0;
  logic        fc_req;
  logic [11:0] fc_credit_limit, fc_blocks_sent;
  logic        cu_valid = 1'b0;
  logic [3:0]  cu_lane = '0;
  logic [11:0] cu_limit = '0;
  logic        tx_req = 1'b0, tx_lane = 1'b0;
  logic [11:0] tx_blocks = '0;
  logic        tx_grant;

  int compared = 0, mismatched = 0, cycles = 0, since_rel = 0;
  bit done = 0;

  // reference model state
  int m_limit, m_sent, m_cnt, m_fcl, m_fcs;
  bit m_have, m_req, m_grant;

  always #5 clk = ~clk;

  credit_flow_ctl u_dut (.*);

  task automatic check(input string tag, input int got, input int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, got, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    int per, nxt_sent;
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      finish_run();
    end
    if (rst) begin
      m_limit = 0; m_sent = 0; m_cnt = 0; m_fcl = 0; m_fcs = 0;
      m_have = 0; m_req = 0; m_grant = 0; since_rel = 0;
    end else begin
      since_rel++;
      m_grant = tx_req && (tx_lane || (m_have && (((m_limit - m_sent - tx_blocks) & 4095) <= 2048)));
      nxt_sent = (m_grant && !tx_lane) ? ((m_sent + tx_blocks) & 4095) : m_sent;
      per = (fc_period == 0) ? 65536 : fc_period;
      if (m_req) begin
        if (fc_ack) begin m_req = 0; m_cnt = 0; end
      end else if (m_cnt >= per - 1) begin
        m_req = 1; m_cnt = 0;
        m_fcl = (buf_rcvd + buf_free) & 4095;
        m_fcs = m_sent;
      end else m_cnt++;
      m_sent = nxt_sent;
      if (cu_valid && cu_lane == 0) begin m_limit = cu_limit; m_have = 1; end
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check("R3 tx_grant", tx_grant, m_grant);
      check("R7 fc_req", fc_req, m_req);
      if (m_req) begin
        check("R9 fc_credit_limit", fc_credit_limit, m_fcl);
        check("R9 fc_blocks_sent", fc_blocks_sent, m_fcs);
      end
    end
  end

  task automatic do_req(input logic ln, input int n, input logic exp, input string tag);
    @(negedge clk); tx_req = 1; tx_lane = ln; tx_blocks = n[11:0];
    @(negedge clk); tx_req = 0;
    check(tag, tx_grant, exp);
  endtask

  task automatic do_cu(input int lane, input int lim);
    @(negedge clk); cu_valid = 1; cu_lane = lane[3:0]; cu_limit = lim[11:0];
    @(negedge clk); cu_valid = 0;
  endtask

  initial begin
    int start;
    repeat (4) @(negedge clk);
    check("R1 fc_req in reset", fc_req, 0);
    check("R1 tx_grant in reset", tx_grant, 0);
    rst = 0;
    @(negedge clk);
    check("R1 fc_req after reset", fc_req, 0);
    buf_rcvd = 12'd4000; buf_free = 12'd200;
    do_req(0, 1, 0, "R2 no credit yet");
    do_req(0, 2048, 0, "R2 no credit, half window");
    do_req(1, 5, 1, "R5 mgmt lane");
    do_cu(0, 10);
    do_req(0, 10, 1, "R3 exact fit");
    do_req(0, 1, 0, "R3 exhausted");
    do_cu(3, 100);
    do_req(0, 1, 0, "R6 foreign lane update ignored");
    do_req(1, 4000, 1, "R5 mgmt ignores credit");
    do_cu(0, 2058);
    do_req(0, 2048, 1, "R3 margin zero");
    do_cu(0, 962);
    do_req(0, 2049, 1, "R4 sum wraps past 4096");
    do_req(0, 952, 0, "R4 count wrapped to 11");
    do_req(0, 951, 1, "R3 fills to limit");
    do_req(0, 2047, 0, "R3 margin 2049 refused");
    do_req(0, 2048, 1, "R3 margin 2048 allowed");
    while (!fc_req) @(negedge clk);
    check("R8 default period", since_rel, 65536);
    check("R9 limit field", fc_credit_limit, 104);
    check("R4 sent field", fc_blocks_sent, 3010);
    repeat (5) @(negedge clk);
    check("R7 held without ack", fc_req, 1);
    fc_period = 17'd13;
    fc_ack = 1;
    @(negedge clk); fc_ack = 0;
    check("R7 dropped on ack", fc_req, 0);
    start = since_rel;
    while (!fc_req) @(negedge clk);
    check("R7 programmed period", since_rel - start, 13);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      tx_req    = (i % 3 != 0);
      tx_lane   = (i % 7 == 0);
      tx_blocks = 12'((i * 37) % 300 + 1);
      cu_valid  = (i % 11 == 0);
      cu_lane   = (i % 22 == 0) ? 4'd5 : 4'd0;
      cu_limit  = 12'((i * 211) % 4096);
      buf_free  = 12'((i * 13) % 4096);
      buf_rcvd  = 12'((i * 29) % 4096);
      fc_ack    = (i % 4 == 1);
      if (i == 200) fc_period = 17'd1;
    end
    @(negedge clk);
    tx_req = 0; cu_valid = 0; fc_ack = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule